// File: doc/BRIEF.md
# Target Time Trigger and Pulse-Per-Second Generator

This block watches a free-running 64-bit time value. The value is split into a seconds word and a subseconds word. The block compares that value against a programmed target and reacts in two ways. The first is a sticky interrupt flag, which is set once the time has reached the target. The second is a one-cycle hardware trigger pulse, which fires once the time has gone strictly past the target. The trigger pulse can be routed to the trigger input of a timer that runs on the same clock. That path has no synchronizer, so the hardware path adds no timing uncertainty, while software servicing the interrupt sees some latency.

The block also produces a pulse-per-second output. Every time the seconds word advances by exactly one, the output goes high for 125 ms. The duration is counted in clock ticks from a programmable ticks-per-millisecond value. Comparing this output across network nodes on an oscilloscope shows how well their clocks agree.

All pins are plain control and status signals. The time inputs are sampled every cycle and have no handshake, so no back-pressure applies. An arm pulse enables a single interrupt event and a single trigger event. Each event consumes its own arming.

Top module: `tt_trig_pps`

## Requirements
- R1: After reset, irq, trig_out, timer_trig and pps_out are all 0.
- R2: When the interrupt path is armed and the time is greater than or equal to the target in a cycle, irq is 1 from the next cycle and stays 1 until cleared.
- R3: A pulse on irq_clr clears irq in the next cycle; if a new interrupt event occurs in the same cycle, the set wins.
- R4: arm_set arms both paths from the next cycle. Each path disarms when it fires, and it fires no more until arm_set is pulsed again, even while the time stays past the target.
- R5: trig_out is a one-cycle pulse in the cycle after a cycle in which the trigger path is armed and the time is strictly greater than the target; equality does not fire it.
- R6: With route_sel = 0, timer_trig equals trig_out in the same cycle (no synchronizer); with route_sel = 1, timer_trig is 0.
- R7: The comparison is unsigned over {seconds, subseconds}, seconds most significant; a larger seconds value wins regardless of subseconds.
- R8: When now_sec equals the previous cycle's now_sec plus 1, pps_out rises in the next cycle and stays high for exactly 125 × ticks_per_ms cycles (ticks_per_ms ≥ 1).
- R9: If now_sec changes by anything other than +1 while pps_out is high, pps_out falls in the next cycle, and no pulse starts until the next +1 step.
- R10: The first cycle after reset only records now_sec and never starts a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by comparator and timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_sec | input | 32 | System time, seconds |
| now_sub | input | 32 | System time, subseconds |
| tgt_sec | input | 32 | Target time, seconds |
| tgt_sub | input | 32 | Target time, subseconds |
| arm_set | input | 1 | One-cycle pulse arming both paths |
| irq_clr | input | 1 | One-cycle pulse clearing the interrupt flag |
| route_sel | input | 1 | 0 routes the trigger to the timer input |
| ticks_per_ms | input | 16 | Clock ticks per millisecond |
| irq | output | 1 | Sticky target-reached interrupt |
| trig_out | output | 1 | Target-passed trigger pulse |
| timer_trig | output | 1 | Timer trigger input after routing |
| pps_out | output | 1 | Pulse-per-second pin |

## Verification
A stale arm bit shows at the ports within one cycle of the time crossing the target: a missing or repeated irq edge, or a repeated trig_out pulse. A bad comparator order shows as soon as the seconds and subseconds words disagree in direction. A wrong pulse counter or a wrong previous-seconds register shows as a pps_out edge that is off by one or more cycles. The bench measures pulse lengths and compares every output against a behavioural model on every clock, so any of these faults shows up in the cycle it happens.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned PPS_HIGH_MS = 125;

  function automatic int unsigned pps_cnt_width(input int unsigned tpm_w);
    return tpm_w + $clog2(PPS_HIGH_MS + 1);
  endfunction
endpackage

// File: rtl/tt_cmp.sv
module tt_cmp #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 32
) (
  input  logic [SEC_W-1:0] now_sec,
  input  logic [SUB_W-1:0] now_sub,
  input  logic [SEC_W-1:0] tgt_sec,
  input  logic [SUB_W-1:0] tgt_sub,
  output logic             reached,
  output logic             passed
);
  logic sec_gt, sec_eq, sub_gt, sub_eq;

  always_comb begin
    sec_gt  = now_sec > tgt_sec;
    sec_eq  = now_sec == tgt_sec;
    sub_gt  = now_sub > tgt_sub;
    sub_eq  = now_sub == tgt_sub;
    // seconds decide first, subseconds only break a tie
    passed  = sec_gt || (sec_eq && sub_gt);
    reached = passed || (sec_eq && sub_eq);
  end
endmodule

// File: rtl/tt_arm.sv
module tt_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic irq_clr,
  input  logic reached,
  input  logic passed,
  output logic irq,
  output logic trig
);
  logic armed_irq, armed_trig, irq_q, trig_q;
  logic fire_irq, fire_trig;

  assign fire_irq  = armed_irq && reached;
  assign fire_trig = armed_trig && passed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_irq  <= 1'b0;
      armed_trig <= 1'b0;
      irq_q      <= 1'b0;
      trig_q     <= 1'b0;
    end else begin
      armed_irq  <= arm_set || (armed_irq && !fire_irq);
      armed_trig <= arm_set || (armed_trig && !fire_trig);
      if (fire_irq)     irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      trig_q <= fire_trig;
    end
  end

  assign irq  = irq_q;
  assign trig = trig_q;

  // R2
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_irq && reached) |=> irq_q);
  // R3
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && irq_clr && !(armed_irq && reached)) |=> !irq_q);
  // R4
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_irq && reached && !arm_set) |=> !armed_irq);
  // R5
  trig_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_trig && passed && !arm_set) |=> (trig_q && !armed_trig));
  // R5
  trig_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed_trig && passed) |=> !trig_q);
endmodule

// File: rtl/tt_pps.sv
module tt_pps #(
  parameter int SEC_W = 32,
  parameter int TPM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] now_sec,
  input  logic [TPM_W-1:0] ticks_per_ms,
  output logic             pps
);
  import tt_pkg::*;
  localparam int CNT_W = pps_cnt_width(TPM_W);

  logic [SEC_W-1:0] prev_sec;
  logic             prev_vld;
  logic             pps_q;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] width;
  logic             step_up, jump;

  assign width   = CNT_W'(ticks_per_ms) * CNT_W'(PPS_HIGH_MS);
  assign step_up = prev_vld && (now_sec == prev_sec + SEC_W'(1));
  assign jump    = prev_vld && (now_sec != prev_sec) && !step_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sec <= '0;
      prev_vld <= 1'b0;
      pps_q    <= 1'b0;
      remain   <= '0;
    end else begin
      prev_sec <= now_sec;
      prev_vld <= 1'b1;
      if (step_up) begin
        pps_q  <= 1'b1;
        remain <= (width == '0) ? '0 : width - CNT_W'(1);
      end else if (pps_q && (jump || remain == '0)) begin
        pps_q <= 1'b0;
      end else if (pps_q) begin
        remain <= remain - CNT_W'(1);
      end
    end
  end

  assign pps = pps_q;

  // R8
  pps_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> pps_q);
  // R8
  pps_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_q && remain != '0 && !jump) |=> pps_q);
  // R9
  pps_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_q && jump) |=> !pps_q);
  // R10
  first_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_vld |=> !pps_q);
endmodule

// File: rtl/tt_trig_pps.sv
module tt_trig_pps #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 32,
  parameter int TPM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] now_sec,
  input  logic [SUB_W-1:0] now_sub,
  input  logic [SEC_W-1:0] tgt_sec,
  input  logic [SUB_W-1:0] tgt_sub,
  input  logic             arm_set,
  input  logic             irq_clr,
  input  logic             route_sel,
  input  logic [TPM_W-1:0] ticks_per_ms,
  output logic             irq,
  output logic             trig_out,
  output logic             timer_trig,
  output logic             pps_out
);
  logic cmp_reached, cmp_passed;

  tt_cmp #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cmp (
    .now_sec(now_sec), .now_sub(now_sub),
    .tgt_sec(tgt_sec), .tgt_sub(tgt_sub),
    .reached(cmp_reached), .passed(cmp_passed)
  );

  tt_arm u_arm (
    .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .irq_clr(irq_clr),
    .reached(cmp_reached), .passed(cmp_passed),
    .irq(irq), .trig(trig_out)
  );

  tt_pps #(.SEC_W(SEC_W), .TPM_W(TPM_W)) u_pps (
    .clk(clk), .rst_n(rst_n), .now_sec(now_sec),
    .ticks_per_ms(ticks_per_ms), .pps(pps_out)
  );

  // same clock domain as the timer: direct, unsynchronized gate
  assign timer_trig = trig_out && !route_sel;

  // R6
  route_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_sel |-> !timer_trig);
  // R7
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_passed |-> cmp_reached);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!irq && !trig_out && !pps_out));
endmodule

// File: tb/sim_tt_trig_pps.sv
module sim_tt_trig_pps;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] now_sec = '0, now_sub = '0, tgt_sec = '0, tgt_sub = '0;
  logic arm_set = 1'b0, irq_clr = 1'b0, route_sel = 1'b0;
  logic [15:0] ticks_per_ms = 16'd2;
  logic irq, trig_out, timer_trig, pps_out;

  always #10 clk = ~clk;

  tt_trig_pps u0 (
    .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_sub(now_sub),
    .tgt_sec(tgt_sec), .tgt_sub(tgt_sub), .arm_set(arm_set),
    .irq_clr(irq_clr), .route_sel(route_sel), .ticks_per_ms(ticks_per_ms),
    .irq(irq), .trig_out(trig_out), .timer_trig(timer_trig), .pps_out(pps_out)
  );

  int checks = 0, fails = 0;
  string phase = "R1";
  bit done = 1'b0;

  // behavioural model state
  bit m_airq, m_atrig, m_irq, m_trig, m_pps, m_pvld;
  longint unsigned m_prev;
  int m_rem;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_airq = 0; m_atrig = 0; m_irq = 0; m_trig = 0;
      m_pps = 0; m_pvld = 0; m_prev = 0; m_rem = 0;
    end else begin
      longint unsigned t_now, t_tgt;
      bit ge, gt;
      t_now = {now_sec, now_sub};
      t_tgt = {tgt_sec, tgt_sub};
      ge = t_now >= t_tgt;
      gt = t_now > t_tgt;
      if (m_airq && ge) m_irq = 1; else if (irq_clr) m_irq = 0;
      m_trig  = m_atrig && gt;
      m_airq  = arm_set || (m_airq && !ge);
      m_atrig = arm_set || (m_atrig && !gt);
      if (m_pvld && longint'(now_sec) == m_prev + 1) begin
        m_pps = 1; m_rem = 125 * int'(ticks_per_ms) - 1;
      end else if (m_pps && m_pvld && longint'(now_sec) != m_prev) begin
        m_pps = 0;
      end else if (m_pps) begin
        if (m_rem == 0) m_pps = 0; else m_rem--;
      end
      m_prev = longint'(now_sec);
      m_pvld = 1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(phase, irq, m_irq, "irq");
      chk(phase, trig_out, m_trig, "trig_out");
      chk(phase, timer_trig, m_trig && !route_sel, "timer_trig");
      chk(phase, pps_out, m_pps, "pps_out");
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_arm();
    arm_set = 1; tick(); arm_set = 0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1; tick(); irq_clr = 0;
  endtask

  task automatic measure_pps(input string tag, input int exp_len);
    int n = 0;
    for (int i = 0; i < 2000; i++) begin
      tick();
      if (pps_out) n++;
      else if (n > 0) break;
    end
    checks++;
    if (n != exp_len) begin
      fails++;
      $display("FAIL %s pps length actual=%0d expected=%0d", tag, n, exp_len);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 / R10: reset with a nonzero seconds value present
    now_sec = 32'd50;
    tick(3);
    phase = "R1";
    chk("R1", irq, 0, "irq reset"); chk("R1", pps_out, 0, "pps reset");
    rst_n = 1;
    phase = "R10";
    tick(4);
    chk("R10", pps_out, 0, "no pulse after first sample");

    // R2 / R5: equality sets irq but not trigger
    phase = "R2";
    tgt_sec = 32'd50; tgt_sub = 32'd100; now_sub = 32'd50;
    pulse_arm(); tick(2);
    now_sub = 32'd100; tick(2);
    chk("R2", irq, 1, "irq at equal time");
    phase = "R5";
    chk("R5", trig_out, 0, "no trig at equal time");
    now_sub = 32'd101; tick();
    chk("R5", trig_out, 1, "trig when past");
    chk("R6", timer_trig, 1, "routed trig");
    tick();
    chk("R5", trig_out, 0, "trig one cycle");

    // R3: clear
    phase = "R3";
    pulse_clr(); tick();
    chk("R3", irq, 0, "irq cleared");
    // R4: stays disarmed while past target
    phase = "R4";
    tick(5);
    chk("R4", irq, 0, "no refire");
    pulse_arm(); tick(2);
    chk("R4", irq, 1, "refire after arm");
    // R3: clear in same cycle as set -> set wins
    phase = "R3";
    arm_set = 1; tick(); arm_set = 0;
    irq_clr = 1; tick(); irq_clr = 0; tick();
    chk("R3", irq, 1, "set wins over clear");
    pulse_clr(); tick();

    // R7: seconds dominate
    phase = "R7";
    tgt_sec = 32'd60; tgt_sub = 32'hFFFF_FFFF;
    now_sec = 32'd59; now_sub = 32'hFFFF_FFFF;
    pulse_arm(); tick(3);
    chk("R7", irq, 0, "lower seconds not reached");
    now_sec = 32'd61; now_sub = 32'd0; tick(2);
    chk("R7", irq, 1, "higher seconds reached");

    // R6: routing blocked
    phase = "R6";
    pulse_clr();
    route_sel = 1;
    tgt_sec = 32'd70; tgt_sub = 0; now_sec = 32'd69;
    pulse_arm(); tick();
    now_sec = 32'd71; tick();
    chk("R6", trig_out, 1, "trig when blocked");
    chk("R6", timer_trig, 0, "timer input blocked");
    tick(); route_sel = 0; tick(3);

    // R8: pulse width 125*2 = 250 cycles
    phase = "R8";
    now_sec = now_sec + 1;
    measure_pps("R8", 250);
    tick(20);
    ticks_per_ms = 16'd1;
    now_sec = now_sec + 1;
    measure_pps("R8", 125);

    // R9: jump during pulse ends it early
    phase = "R9";
    ticks_per_ms = 16'd2;
    now_sec = now_sec + 1; tick(10);
    chk("R9", pps_out, 1, "pulse high before jump");
    now_sec = 32'd500; tick();
    chk("R9", pps_out, 0, "pulse ended by jump");
    tick(20);
    chk("R9", pps_out, 0, "no pulse after jump");
    now_sec = 32'd501;
    measure_pps("R9", 250);

    tick(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule